// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises port-to-port message interrupts for a memory shared by a left and a right port. It watches each port's address, chip enable, read and write strobes on a common clock. The two highest words of the address space serve as mailboxes. The topmost word belongs to the right port and the word just below it belongs to the left port. When one port writes the other port's mailbox, the owner's interrupt line goes active. It stays active until the owner reads its own mailbox.

Each port also has a busy input from the contention arbiter. While busy is high for a port, that port's mailbox accesses neither raise nor clear an interrupt. The memory array, the message contents and the arbitration itself lie outside this block. The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While synchronous reset is high, both interrupt outputs go high (inactive) at the next clock edge. Interrupt outputs are active-low.
- R2: A left-port access with ce=1, wr=1 and address all-ones drives rIntN low from the next clock edge.
- R3: A right-port access with ce=1, wr=1 and address all-ones minus one drives lIntN low from the next clock edge.
- R4: A port reading its own mailbox (ce=1, rd=1, owner's address) returns its interrupt output high from the next clock edge.
- R5: A port reading the other port's mailbox leaves both interrupt outputs unchanged.
- R6: While a port's busy input is high, its write to the other port's mailbox does not activate the other port's interrupt.
- R7: While a port's busy input is high, its read of its own mailbox does not clear its own interrupt.
- R8: If a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up active.
- R9: Accesses with ce=0, accesses to any non-mailbox address, and writes by a port to its own mailbox do not change either interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lAddr | input | ADDR_W | Left port address |
| lCe | input | 1 | Left port chip enable, active high |
| lRd | input | 1 | Left port read strobe |
| lWr | input | 1 | Left port write strobe |
| lBusy | input | 1 | Busy from the arbiter to the left port |
| rAddr | input | ADDR_W | Right port address |
| rCe | input | 1 | Right port chip enable, active high |
| rRd | input | 1 | Right port read strobe |
| rWr | input | 1 | Right port write strobe |
| rBusy | input | 1 | Busy from the arbiter to the right port |
| lIntN | output | 1 | Left port interrupt, active low |
| rIntN | output | 1 | Right port interrupt, active low |

## Verification
A set and a clear of one interrupt can land in the same cycle. This happens when one port writes a mailbox while the owner reads that same mailbox. The bench drives that collision directly, with and without busy on either side, and also drives it through biased random traffic that concentrates addresses on the two mailboxes. A behavioural reference model is compared against both outputs on every clock. The final state of each collision is judged against the rule that a set overrides a clear unless busy blocks the set.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Per-flag strobes from the control side to the flag datapath.
  // Index 0 is the left port's interrupt, index 1 the right port's.
  typedef struct packed {
    logic [1:0] setV;
    logic [1:0] clrV;
  } irqStrobes_t;

  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int ADDR_W = 10,
  parameter bit OWN_IS_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce,
  input  logic              rd,
  input  logic              wr,
  input  logic              busy,
  output logic              wrOtherBox,
  output logic              rdOwnBox
);
  localparam logic [ADDR_W-1:0] TOP_BOX  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_BOX = TOP_BOX - 1'b1;
  localparam logic [ADDR_W-1:0] OWN_BOX   = OWN_IS_TOP ? TOP_BOX : NEXT_BOX;
  localparam logic [ADDR_W-1:0] OTHER_BOX = OWN_IS_TOP ? NEXT_BOX : TOP_BOX;

  logic hitOwn, hitOther, active;

  always_comb begin
    hitOwn     = (addr == OWN_BOX);
    hitOther   = (addr == OTHER_BOX);
    active     = ce && !busy;
    wrOtherBox = active && wr && hitOther;
    rdOwnBox   = active && rd && hitOwn;
  end

  // R6 / R7: a busy port produces no strobe at all.
  always_comb begin
    p_busy_gates_r6: assert (!(busy && (wrOtherBox || rdOwnBox)));
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lCe,
  input  logic              lRd,
  input  logic              lWr,
  input  logic              lBusy,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rCe,
  input  logic              rRd,
  input  logic              rWr,
  input  logic              rBusy,
  output irqStrobes_t       strobes
);
  logic [ADDR_W-1:0] addrV [2];
  logic [1:0] ceV, rdV, wrV, busyV, wrOther, rdOwn;

  always_comb begin
    addrV[SIDE_L] = lAddr;  addrV[SIDE_R] = rAddr;
    ceV   = {rCe, lCe};
    rdV   = {rRd, lRd};
    wrV   = {rWr, lWr};
    busyV = {rBusy, lBusy};
  end

  for (genvar s = 0; s < 2; s++) begin : g_port
    mbox_port_decode #(
      .ADDR_W(ADDR_W),
      .OWN_IS_TOP(s == SIDE_R)
    ) u_dec (
      .addr(addrV[s]),
      .ce(ceV[s]),
      .rd(rdV[s]),
      .wr(wrV[s]),
      .busy(busyV[s]),
      .wrOtherBox(wrOther[s]),
      .rdOwnBox(rdOwn[s])
    );
  end

  // A port's write to the opposite box sets the opposite flag;
  // its read of its own box clears its own flag.
  always_comb begin
    strobes.setV[SIDE_L] = wrOther[SIDE_R];
    strobes.setV[SIDE_R] = wrOther[SIDE_L];
    strobes.clrV         = rdOwn;
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  irqStrobes_t strobes,
  output logic        lIntN,
  output logic        rIntN
);
  logic [1:0] pendQ;

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                  pendQ[i] <= 1'b0;
      else if (strobes.setV[i]) pendQ[i] <= 1'b1;  // R8: set wins
      else if (strobes.clrV[i]) pendQ[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (strobes.setV[i] && strobes.clrV[i]) |=> pendQ[i]);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!strobes.setV[i] && !strobes.clrV[i]) |=> $stable(pendQ[i]));
  end

  assign lIntN = !pendQ[SIDE_L];
  assign rIntN = !pendQ[SIDE_R];
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lCe,
  input  logic              lRd,
  input  logic              lWr,
  input  logic              lBusy,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rCe,
  input  logic              rRd,
  input  logic              rWr,
  input  logic              rBusy,
  output logic              lIntN,
  output logic              rIntN
);
  irqStrobes_t strobes;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .lAddr(lAddr), .lCe(lCe), .lRd(lRd), .lWr(lWr), .lBusy(lBusy),
    .rAddr(rAddr), .rCe(rCe), .rRd(rRd), .rWr(rWr), .rBusy(rBusy),
    .strobes(strobes)
  );

  mbox_flags u_flags (
    .clk(clk), .rst(rst), .strobes(strobes),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (lIntN && rIntN));
  p_left_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (lCe && lWr && !lBusy && lAddr == R_BOX) |=> !rIntN);
  p_right_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (rCe && rWr && !rBusy && rAddr == L_BOX) |=> !lIntN);
  p_busy_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (lBusy && rIntN) |=> rIntN);
  p_busy_no_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (rBusy && !rIntN) |=> !rIntN);
  p_owner_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!lIntN && !(lCe && lRd && !lBusy && lAddr == L_BOX)) |=> !lIntN);
endmodule

// File: tb/sim_mbox_irq_ctrl.sv
module sim_mbox_irq_ctrl;
  localparam int AW = 10;
  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lCe = 0, lRd = 0, lWr = 0, lBusy = 0;
  logic rCe = 0, rRd = 0, rWr = 0, rBusy = 0;
  logic lIntN, rIntN;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R1";
  bit mL = 1'b0, mR = 1'b0;  // model: pending flags

  always #5 clk = ~clk;

  mbox_irq_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst),
    .lAddr(lAddr), .lCe(lCe), .lRd(lRd), .lWr(lWr), .lBusy(lBusy),
    .rAddr(rAddr), .rCe(rCe), .rRd(rRd), .rWr(rWr), .rBusy(rBusy),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  task automatic compare();
    checks++;
    if (lIntN !== !mL) begin
      errors++;
      $display("FAIL %s lIntN actual %b expected %b", req, lIntN, !mL);
    end
    checks++;
    if (rIntN !== !mR) begin
      errors++;
      $display("FAIL %s rIntN actual %b expected %b", req, rIntN, !mR);
    end
  endtask

  // Advance the model for the inputs now applied (effect after next edge).
  task automatic model_step();
    bit sL, sR, cL, cR;
    sR = lCe && lWr && !lBusy && lAddr == RBOX;
    sL = rCe && rWr && !rBusy && rAddr == LBOX;
    cL = lCe && lRd && !lBusy && lAddr == LBOX;
    cR = rCe && rRd && !rBusy && rAddr == RBOX;
    if (rst) begin mL = 0; mR = 0; end
    else begin
      mL = sL ? 1'b1 : (cL ? 1'b0 : mL);
      mR = sR ? 1'b1 : (cR ? 1'b0 : mR);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, check at the next one.
  task automatic cyc(input string r,
                     input bit lc, input bit lr, input bit lw, input bit lb, input logic [AW-1:0] la,
                     input bit rc, input bit rr, input bit rw, input bit rb, input logic [AW-1:0] ra);
    req = r;
    lCe = lc; lRd = lr; lWr = lw; lBusy = lb; lAddr = la;
    rCe = rc; rRd = rr; rWr = rw; rBusy = rb; rAddr = ra;
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input string r);
    cyc(r, 0,0,0,0,'0, 0,0,0,0,'0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; model_step();
    @(negedge clk); compare();              // R1 reset state
    rst = 1'b0;
    idle("R1");
    // R2: left writes right box
    cyc("R2", 1,0,1,0,RBOX, 0,0,0,0,'0);
    // R5: left reads right box, right flag stays
    cyc("R5", 1,1,0,0,RBOX, 0,0,0,0,'0);
    // R4: right reads own box -> cleared
    cyc("R4", 0,0,0,0,'0, 1,1,0,0,RBOX);
    // R3: right writes left box
    cyc("R3", 0,0,0,0,'0, 1,0,1,0,LBOX);
    // R5: right reads left box, no change
    cyc("R5", 0,0,0,0,'0, 1,1,0,0,LBOX);
    // R7: left busy read own box, no clear
    cyc("R7", 1,1,0,1,LBOX, 0,0,0,0,'0);
    // R4: left reads own box, cleared
    cyc("R4", 1,1,0,0,LBOX, 0,0,0,0,'0);
    // R6: busy writers do not set
    cyc("R6", 1,0,1,1,RBOX, 1,0,1,1,LBOX);
    // R9: ce low, other address, own-box writes
    cyc("R9", 0,0,1,0,RBOX, 0,0,1,0,LBOX);
    cyc("R9", 1,0,1,0,RBOX-2, 1,0,1,0,3);
    cyc("R9", 1,0,1,0,LBOX, 1,0,1,0,RBOX);
    // R8: set and clear same cycle
    cyc("R8", 1,0,1,0,RBOX, 0,0,0,0,'0);
    cyc("R8", 1,0,1,0,RBOX, 1,1,0,0,RBOX);
    cyc("R8", 1,1,0,0,LBOX, 1,0,1,0,LBOX);
    // R8 with busy blocking the set: clear happens
    cyc("R8", 1,1,0,0,LBOX, 1,0,1,1,LBOX);
    // R1: reset while flags pending
    cyc("R1", 1,0,1,0,RBOX, 1,0,1,0,LBOX);
    rst = 1'b1; cyc("R1", 0,0,0,0,'0, 0,0,0,0,'0);
    rst = 1'b0; idle("R1");
    // Random traffic biased to the mailboxes
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la, ra;
      int pl, pr;
      pl = $urandom_range(0, 3); pr = $urandom_range(0, 3);
      la = (pl == 0) ? RBOX : (pl == 1) ? LBOX : AW'($urandom);
      ra = (pr == 0) ? RBOX : (pr == 1) ? LBOX : AW'($urandom);
      cyc("R8", 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
                1'($urandom_range(0, 4) == 0), la,
                1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
                1'($urandom_range(0, 4) == 0), ra);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule